// File: doc/BRIEF.md
# Dual-Output Driver Control Logic

This block is the digital control core of a two-channel power-switch driver. Two command inputs, one of inverting sense and one of non-inverting sense, are merged into a single drive command. The command is high only while the inverting input is low and the non-inverting input is high. The block turns that command into two output enables, A and B. In parallel mode both enables follow the command together, so the two channels can share a load. In alternating mode an internal toggle steers each new command pulse to the channel that did not carry the previous one.

The toggle advances only after the command has stayed low for a minimum off-time. A shutdown request forces both enables low at once and stays latched. The latch releases only after the request has gone and the command has been low for that same off-time. An over-temperature flag forces both enables low for as long as it is present. Each channel has an inhibit input that keeps that channel from turning on. All flag and command inputs are asynchronous and pass through two-flop synchronizers. The off-time is a parameter counted in clock cycles.

Top module: `dual_drive_ctl`

## Requirements
- R1: Once synchronized, the drive command is high only for inverting input 0 with non-inverting input 1. A change at these ports shows on the enables after the second rising clock edge, and not before it.
- R2: With the alternate-enable input at 0, both enables equal the command in every cycle when no shutdown, over-temperature or inhibit is active.
- R3: With the alternate-enable input at 1, the two enables are never high together. The first pulse after reset drives A. Pulses separated by a long enough gap alternate A, B, A, and so on.
- R4: The toggle advances only when the synchronized command has been low for at least OFF_CYC consecutive cycles. A shorter gap leaves the next pulse on the same channel.
- R5: A synchronized shutdown request drives both enables low in the same cycle. The latch then holds them low after the request drops. It clears only when the request is gone and the command has been low for at least OFF_CYC cycles.
- R6: A pulse cut short by a shutdown still counts as a pulse when choosing the next channel.
- R7: The synchronized over-temperature flag forces both enables low while it is high, and it latches nothing.
- R8: An asserted inhibit for a channel keeps that channel's enable low. It has no effect on the other channel.
- R9: During and right after reset both enables are low, channel A is selected and the shutdown latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_inv | input | 1 | Inverting command input (async) |
| cmd_ni | input | 1 | Non-inverting command input (async) |
| alt_en | input | 1 | 1 = alternate pulses between A and B, 0 = parallel |
| sd_req | input | 1 | Shutdown request, latched (async) |
| ot_flag | input | 1 | Over-temperature flag, level acting (async) |
| inh_a | input | 1 | Inhibit for channel A (async) |
| inh_b | input | 1 | Inhibit for channel B (async) |
| drv_a | output | 1 | Enable for channel A |
| drv_b | output | 1 | Enable for channel B |

## Verification
A stuck or wrong channel-select bit shows at the ports on the next pulse in alternating mode, when the wrong enable rises. A toggle that advances after too short a gap shows the same way. A shutdown latch that clears too early, or fails to clear, shows in the first cycle of the next pulse, when an enable rises when it should stay low or stays low when it should rise. The bench runs a behavioural model beside the design and compares both enables on every clock. Each of these faults is therefore reported in the exact cycle it first becomes visible.

// File: rtl/dual_drive_ctl.sv
module dual_drive_ctl #(
  parameter int OFF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_inv,
  input  logic cmd_ni,
  input  logic alt_en,
  input  logic sd_req,
  input  logic ot_flag,
  input  logic inh_a,
  input  logic inh_b,
  output logic drv_a,
  output logic drv_b
);
  localparam int CW = $clog2(OFF_CYC + 1);

  logic [6:0] s1, s2;
  logic [CW-1:0] cnt;
  logic pend, sel, sd_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {inh_b, inh_a, ot_flag, sd_req, alt_en, cmd_ni, cmd_inv};
      s2 <= s1;
    end

  wire inv_s = s2[0];
  wire ni_s  = s2[1];
  wire alt_s = s2[2];
  wire sd_s  = s2[3];
  wire ot_s  = s2[4];
  wire iha_s = s2[5];
  wire ihb_s = s2[6];

  wire cmd      = ~inv_s & ni_s;
  wire off_done = ~cmd & (cnt >= CW'(OFF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= CW'(OFF_CYC);
      pend   <= 1'b0;
      sel    <= 1'b0;
      sd_lat <= 1'b0;
    end else begin
      if (cmd) cnt <= '0;
      else if (cnt < CW'(OFF_CYC)) cnt <= cnt + 1'b1;

      if (cmd) pend <= 1'b1;
      else if (pend && off_done) begin
        pend <= 1'b0;
        if (alt_s) sel <= ~sel;
      end

      if (sd_s) sd_lat <= 1'b1;
      else if (off_done) sd_lat <= 1'b0;
    end

  wire run = cmd & ~sd_s & ~sd_lat & ~ot_s;
  assign drv_a = run & ~iha_s & (~alt_s | ~sel);
  assign drv_b = run & ~ihb_s & (~alt_s | sel);

  assert_ot_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |-> (!drv_a && !drv_b));
  assert_sd_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_s || sd_lat) |-> (!drv_a && !drv_b));
  assert_lat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_lat && cmd) |=> sd_lat);
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alt_s |-> !(drv_a && drv_b));
  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> $stable(sel));
  assert_inh_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iha_s |-> !drv_a);
  assert_inh_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ihb_s |-> !drv_b);
endmodule

// File: tb/sim_dual_drive_ctl.sv
module sim_dual_drive_ctl;
  localparam int OFF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_inv = 1'b1, cmd_ni = 1'b0, alt_en = 1'b0;
  logic sd_req = 1'b0, ot_flag = 1'b0, inh_a = 1'b0, inh_b = 1'b0;
  logic drv_a, drv_b;

  dual_drive_ctl #(.OFF_CYC(OFF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_inv(cmd_inv), .cmd_ni(cmd_ni),
    .alt_en(alt_en), .sd_req(sd_req), .ot_flag(ot_flag),
    .inh_a(inh_a), .inh_b(inh_b), .drv_a(drv_a), .drv_b(drv_b));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R9";
  bit done = 1'b0;

  // behavioural reference: inputs delayed two clocks, then modelled state
  bit q1[7], q2[7];
  int low_run = OFF;
  bit m_pend = 0, m_sel = 0, m_lat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (q1[i]) begin q1[i] = 0; q2[i] = 0; end
      low_run = OFF; m_pend = 0; m_sel = 0; m_lat = 0;
    end else begin
      bit c;
      c = !q2[0] && q2[1];
      if (c) begin
        low_run = 0; m_pend = 1;
      end else begin
        low_run = (low_run + 1 > OFF) ? OFF : low_run + 1;
        if (m_pend && low_run >= OFF) begin
          m_pend = 0;
          if (q2[2]) m_sel = !m_sel;
        end
      end
      if (q2[3]) m_lat = 1;
      else if (!c && low_run >= OFF) m_lat = 0;
      q2 = q1;
      q1 = '{cmd_inv, cmd_ni, alt_en, sd_req, ot_flag, inh_a, inh_b};
    end
  end

  task automatic check(input bit got, input bit exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", cur_req, what, cyc, got, exp);
    end
  endtask

  always @(negedge clk) begin
    bit run, ea, eb;
    cyc++;
    run = (!q2[0] && q2[1]) && !q2[3] && !m_lat && !q2[4];
    ea = rst_n && run && !q2[5] && (!q2[2] || !m_sel);
    eb = rst_n && run && !q2[6] && (!q2[2] || m_sel);
    if (!done) begin
      check(drv_a, ea, "drv_a");
      check(drv_b, eb, "drv_b");
    end
    if (cyc > 20000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    cmd_inv = 0; cmd_ni = 1; idle(hi);
    cmd_inv = 1; cmd_ni = 0; idle(lo);
  endtask

  initial begin
    cur_req = "R9"; idle(4);
    rst_n = 1; idle(4);
    cur_req = "R1";
    cmd_inv = 0; cmd_ni = 0; idle(4);
    cmd_inv = 1; cmd_ni = 1; idle(4);
    cmd_inv = 0; cmd_ni = 1; idle(1);
    check(drv_a, 1'b0, "latency edge1");
    idle(1);
    check(drv_a, 1'b1, "latency edge2");
    idle(4);
    cmd_inv = 1; cmd_ni = 0; idle(25);
    cur_req = "R2";
    pulse(6, 3); pulse(8, 25); pulse(3, 25);
    cur_req = "R3";
    alt_en = 1; idle(25);
    pulse(5, 30);
    pulse(5, 30);
    pulse(5, 30);
    cur_req = "R4";
    pulse(5, OFF - 4); pulse(5, OFF - 1); pulse(5, OFF); pulse(5, OFF + 1);
    pulse(4, 3); pulse(4, 30);
    cur_req = "R5";
    cmd_inv = 0; cmd_ni = 1; idle(4);
    sd_req = 1; idle(3); sd_req = 0; idle(5);
    cmd_inv = 1; cmd_ni = 0; idle(6);
    cur_req = "R6";
    pulse(5, 30); pulse(5, 30);
    cur_req = "R5";
    sd_req = 1; idle(4); sd_req = 0; idle(4);
    pulse(5, 30);
    cur_req = "R7";
    cmd_inv = 0; cmd_ni = 1; idle(3);
    ot_flag = 1; idle(5); ot_flag = 0; idle(5);
    cmd_inv = 1; cmd_ni = 0; idle(30);
    cur_req = "R8";
    inh_a = 1; pulse(5, 30); pulse(5, 30); inh_a = 0;
    alt_en = 0; inh_b = 1; pulse(6, 30); inh_b = 0; pulse(6, 30);
    cur_req = "R9";
    rst_n = 0; cmd_inv = 0; cmd_ni = 1; idle(3);
    check(drv_a, 1'b0, "in reset"); check(drv_b, 1'b0, "in reset");
    alt_en = 1; rst_n = 1; idle(6);
    cmd_inv = 1; cmd_ni = 0; idle(30);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule